// File: doc/BRIEF.md
# Tristate Phase-Frequency Detector with Four-Level Pump Mode

This block sits between the two dividers of a frequency synthesizer and the analog charge pump. It takes single-cycle pulses from the reference divider and from the feedback divider, both in the same clock domain. It keeps a tristate detector state that shows which divider edge arrived first. The pump request outputs UP and DN tell the charge pump to source or sink current. When neither is raised, the pump output is high impedance.

A 2-bit mode input does four jobs at once. It sets the pump current code, it can disable the pump, it raises a flag that grounds the loop-filter amplifier input, and it selects which divider pulse stream is copied to a test output. Every output is registered, so each result appears one clock after the inputs that cause it are sampled.

Top module: `pfd_ctl`

## Requirements
- R1: While reset is high, and on the first edge after it, pump_up_o, pump_dn_o, isel_o, filt_gnd_o and test_o are all 0.
- R2: A reference pulse with no feedback request pending raises pump_up_o. It stays high until a feedback pulse arrives.
- R3: A feedback pulse with no reference request pending raises pump_dn_o. It stays high until a reference pulse arrives.
- R4: When the lagging pulse arrives, pump_up_o and pump_dn_o are both high for exactly one cycle. After that both return to 0.
- R5: Reference and feedback pulses in the same cycle, with nothing pending, leave both pump requests at 0.
- R6: Mode 2'b00 (low) gives isel_o = 2'b01 (200 µA). In this mode the pump is enabled and filt_gnd_o = 0.
- R7: Mode 2'b01 (high) gives isel_o = 2'b10 (300 µA). In this mode the pump is enabled and filt_gnd_o = 0.
- R8: Mode 2'b10 (mid) gives isel_o = 2'b00 (zero current) and forces both pump requests to 0. test_o follows the feedback pulse.
- R9: Mode 2'b11 (open) gives isel_o = 2'b00 and forces both pump requests to 0. It sets filt_gnd_o = 1, and test_o follows the reference pulse.
- R10: In modes 2'b00 and 2'b01, test_o stays 0 for any divider pulse.
- R11: The detector state keeps updating while the pump is disabled. A request pending at that time appears on the pump outputs as soon as an enabling mode is applied.
- R12: Every output changes on the clock edge that samples its inputs, never before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| ref_pulse_i | input | 1 | Single-cycle pulse from the reference divider |
| fb_pulse_i | input | 1 | Single-cycle pulse from the feedback divider |
| mode_i | input | 2 | Pump mode: 00 low, 01 high, 10 mid, 11 open |
| pump_up_o | output | 1 | Request for the pump to source current |
| pump_dn_o | output | 1 | Request for the pump to sink current |
| isel_o | output | 2 | Pump current code: 00 off, 01 200 µA, 10 300 µA |
| filt_gnd_o | output | 1 | Grounds the loop-filter amplifier input |
| test_o | output | 1 | Selected divider pulse stream for test |

## Verification
Every output is due one clock after the edge that samples the pulse or mode that causes it. A lagging pulse clears the overlapped requests two edges after it is applied. The bench drives inputs 1 ns after a rising edge and samples 1 ns after the next rising edge, so every check sees the value registered at that edge. For R12, it also samples once right after driving a pulse to confirm that nothing has moved before the edge. The overlap and clearing checks are made on consecutive edges, so the one-cycle length of the both-high state is confirmed exactly.

// File: rtl/pfd_ctl_pkg.sv
package pfd_ctl_pkg;
  localparam int MODE_W = 2;
  localparam int ISEL_W = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_LOW  = 2'b00,
    MODE_HIGH = 2'b01,
    MODE_MID  = 2'b10,
    MODE_OPEN = 2'b11
  } pump_mode_e;

  localparam logic [ISEL_W-1:0] ISEL_OFF = 2'b00;
  localparam logic [ISEL_W-1:0] ISEL_200 = 2'b01;
  localparam logic [ISEL_W-1:0] ISEL_300 = 2'b10;

  typedef struct packed {
    logic              pump_en;
    logic [ISEL_W-1:0] isel;
    logic              filt_gnd;
    logic              tap_fb;
    logic              tap_ref;
  } mode_cfg_t;
endpackage

// File: rtl/pfd_mode_dec.sv
module pfd_mode_dec
  import pfd_ctl_pkg::*;
(
  input  logic [MODE_W-1:0] mode_i,
  output mode_cfg_t         cfg_o
);
  always_comb begin
    cfg_o = '0;
    case (pump_mode_e'(mode_i))
      MODE_LOW: begin
        cfg_o.pump_en = 1'b1;
        cfg_o.isel    = ISEL_200;
      end
      MODE_HIGH: begin
        cfg_o.pump_en = 1'b1;
        cfg_o.isel    = ISEL_300;
      end
      MODE_MID: begin
        cfg_o.isel   = ISEL_OFF;
        cfg_o.tap_fb = 1'b1;
      end
      MODE_OPEN: begin
        cfg_o.isel     = ISEL_OFF;
        cfg_o.filt_gnd = 1'b1;
        cfg_o.tap_ref  = 1'b1;
      end
      default: cfg_o = '0;
    endcase
  end
endmodule

// File: rtl/pfd_core.sv
module pfd_core (
  input  logic clk_i,
  input  logic rst_i,
  input  logic ref_i,
  input  logic fb_i,
  output logic up_nx_o,
  output logic dn_nx_o
);
  logic up_q, dn_q;
  logic up_d, dn_d;

  always_comb begin
    if (up_q && dn_q) begin
      up_d = ref_i && !fb_i;
      dn_d = fb_i && !ref_i;
    end else begin
      up_d = up_q || (ref_i && (!fb_i || dn_q));
      dn_d = dn_q || (fb_i && (!ref_i || up_q));
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      up_q <= 1'b0;
      dn_q <= 1'b0;
    end else begin
      up_q <= up_d;
      dn_q <= dn_d;
    end
  end

  assign up_nx_o = up_d;
  assign dn_nx_o = dn_d;

  // R4
  overlap_once_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (up_q && dn_q) |=> !(up_q && dn_q));

  // R5
  aligned_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (ref_i && fb_i && !up_q && !dn_q) |=> (!up_q && !dn_q));

  // R2
  up_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (up_q && !dn_q && !fb_i) |=> up_q);

  // R3
  dn_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (dn_q && !up_q && !ref_i) |=> dn_q);
endmodule

// File: rtl/pfd_out_stage.sv
module pfd_out_stage
  import pfd_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  mode_cfg_t         cfg_i,
  input  logic              up_nx_i,
  input  logic              dn_nx_i,
  input  logic              ref_i,
  input  logic              fb_i,
  output logic              up_o,
  output logic              dn_o,
  output logic [ISEL_W-1:0] isel_o,
  output logic              filt_gnd_o,
  output logic              test_o
);
  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      up_o       <= 1'b0;
      dn_o       <= 1'b0;
      isel_o     <= ISEL_OFF;
      filt_gnd_o <= 1'b0;
      test_o     <= 1'b0;
    end else begin
      up_o       <= up_nx_i && cfg_i.pump_en;
      dn_o       <= dn_nx_i && cfg_i.pump_en;
      isel_o     <= cfg_i.isel;
      filt_gnd_o <= cfg_i.filt_gnd;
      test_o     <= (cfg_i.tap_fb && fb_i) || (cfg_i.tap_ref && ref_i);
    end
  end
endmodule

// File: rtl/pfd_ctl.sv
module pfd_ctl
  import pfd_ctl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              ref_pulse_i,
  input  logic              fb_pulse_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              pump_up_o,
  output logic              pump_dn_o,
  output logic [ISEL_W-1:0] isel_o,
  output logic              filt_gnd_o,
  output logic              test_o
);
  mode_cfg_t cfg;
  logic      up_nx, dn_nx;

  pfd_mode_dec u_dec (
    .mode_i (mode_i),
    .cfg_o  (cfg)
  );

  pfd_core u_core (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .ref_i   (ref_pulse_i),
    .fb_i    (fb_pulse_i),
    .up_nx_o (up_nx),
    .dn_nx_o (dn_nx)
  );

  pfd_out_stage u_out (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .cfg_i      (cfg),
    .up_nx_i    (up_nx),
    .dn_nx_i    (dn_nx),
    .ref_i      (ref_pulse_i),
    .fb_i       (fb_pulse_i),
    .up_o       (pump_up_o),
    .dn_o       (pump_dn_o),
    .isel_o     (isel_o),
    .filt_gnd_o (filt_gnd_o),
    .test_o     (test_o)
  );

  // R8
  pump_off_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_i[1]) |=> (!pump_up_o && !pump_dn_o));

  // R6
  isel_code_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_i == MODE_LOW) |=> (isel_o == ISEL_200));

  // R7
  isel_hi_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_i == MODE_HIGH) |=> (isel_o == ISEL_300));

  // R10
  test_quiet_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (!mode_i[1]) |=> !test_o);

  // R9
  filt_gnd_chk: assert property (@(posedge clk_i) disable iff (rst_i)
    (mode_i == MODE_OPEN) |=> filt_gnd_o);
endmodule

// File: tb/test_pfd_ctl.sv
module test_pfd_ctl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ref_p = 1'b0;
  logic       fb_p = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       up, dn, fgnd, tst;
  logic [1:0] isel;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pfd_ctl i_pfd_ctl (
    .clk_i       (clk),
    .rst_i       (rst),
    .ref_pulse_i (ref_p),
    .fb_pulse_i  (fb_p),
    .mode_i      (mode),
    .pump_up_o   (up),
    .pump_dn_o   (dn),
    .isel_o      (isel),
    .filt_gnd_o  (fgnd),
    .test_o      (tst)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [3:0] act, logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(logic r, logic f);
    ref_p = r;
    fb_p  = f;
    tick();
    ref_p = 1'b0;
    fb_p  = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    tick();
    tick();
    check("R1 outputs in reset", {up, dn, fgnd, tst}, 4'h0);
    check("R1 isel in reset", {2'b00, isel}, 4'h0);
    rst = 1'b0;
  endtask

  task automatic t_ref_lead();
    mode = 2'b00;
    tick();
    ref_p = 1'b1;
    #1;
    check("R12 no change before edge", {2'b00, up, dn}, 4'h0);
    tick();
    ref_p = 1'b0;
    check("R2 up raised", {2'b00, up, dn}, 4'h2);
    check("R6 isel 200", {2'b00, isel}, 4'h1);
    check("R6 no filter ground", {3'b000, fgnd}, 4'h0);
    tick();
    tick();
    check("R2 up held", {2'b00, up, dn}, 4'h2);
    pulse(1'b0, 1'b1);
    check("R4 overlap", {2'b00, up, dn}, 4'h3);
    tick();
    check("R4 cleared", {2'b00, up, dn}, 4'h0);
    tick();
    check("R4 stays clear", {2'b00, up, dn}, 4'h0);
  endtask

  task automatic t_fb_lead();
    mode = 2'b01;
    tick();
    check("R7 isel 300", {2'b00, isel}, 4'h2);
    pulse(1'b0, 1'b1);
    check("R3 dn raised", {2'b00, up, dn}, 4'h1);
    tick();
    check("R3 dn held", {2'b00, up, dn}, 4'h1);
    pulse(1'b1, 1'b0);
    check("R4 overlap dn lead", {2'b00, up, dn}, 4'h3);
    tick();
    check("R4 cleared dn lead", {2'b00, up, dn}, 4'h0);
  endtask

  task automatic t_aligned();
    mode = 2'b00;
    pulse(1'b1, 1'b1);
    check("R5 aligned neither", {2'b00, up, dn}, 4'h0);
    tick();
    check("R5 aligned still neither", {2'b00, up, dn}, 4'h0);
  endtask

  task automatic t_mid();
    mode = 2'b10;
    tick();
    check("R8 isel off", {2'b00, isel}, 4'h0);
    check("R8 no ground, test idle", {2'b00, fgnd, tst}, 4'h0);
    pulse(1'b0, 1'b1);
    check("R8 test follows fb", {3'b000, tst}, 4'h1);
    check("R8 pump forced off", {2'b00, up, dn}, 4'h0);
    tick();
    check("R8 test back low", {3'b000, tst}, 4'h0);
    pulse(1'b1, 1'b0);
    check("R8 ref not on test", {3'b000, tst}, 4'h0);
    tick();
    tick();
  endtask

  task automatic t_hold();
    mode = 2'b10;
    pulse(1'b1, 1'b0);
    check("R11 hidden while off", {2'b00, up, dn}, 4'h0);
    tick();
    mode = 2'b00;
    tick();
    check("R11 pending up shows", {2'b00, up, dn}, 4'h2);
    pulse(1'b0, 1'b1);
    tick();
    check("R11 cleared afterwards", {2'b00, up, dn}, 4'h0);
  endtask

  task automatic t_open();
    mode = 2'b11;
    tick();
    check("R9 filter ground", {3'b000, fgnd}, 4'h1);
    check("R9 isel off", {2'b00, isel}, 4'h0);
    pulse(1'b1, 1'b0);
    check("R9 test follows ref", {3'b000, tst}, 4'h1);
    check("R9 pump forced off", {2'b00, up, dn}, 4'h0);
    pulse(1'b0, 1'b1);
    check("R9 fb not on test", {3'b000, tst}, 4'h0);
    tick();
  endtask

  task automatic t_quiet_test();
    mode = 2'b00;
    pulse(1'b1, 1'b0);
    check("R10 low mode test idle on ref", {3'b000, tst}, 4'h0);
    check("R10 ground dropped", {3'b000, fgnd}, 4'h0);
    pulse(1'b0, 1'b1);
    tick();
    mode = 2'b01;
    pulse(1'b0, 1'b1);
    check("R10 high mode test idle on fb", {3'b000, tst}, 4'h0);
    pulse(1'b1, 1'b0);
    tick();
    check("R10 pump clear after pair", {2'b00, up, dn}, 4'h0);
  endtask

  initial begin
    #1;
    t_reset();
    t_ref_lead();
    t_fb_lead();
    t_aligned();
    t_mid();
    t_hold();
    t_open();
    t_quiet_test();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule